// File: doc/BRIEF.md
# Chained DMA Descriptor Sequencer

This block steers a serial port's DMA engine through a run of transfers. Software programs the first transfer directly: it writes a start address (index), a signed address step (modifier) and a word count into live parameter registers. When chaining is used, software also writes a link pointer. The link pointer holds the memory address of a four-word descriptor that defines the second transfer. Each descriptor in turn links to the next one, and a link of zero closes the chain.

For the running transfer, the sequencer presents one word address at a time to an external data mover. It steps the address after each word that the mover reports as done. When the count is used up, it reads the next descriptor word by word over a simple memory read port. It then swaps all four values into the live registers in one cycle and starts the next transfer.

A transfer only begins when several conditions hold together, and a running chain cannot be altered from software. The block also runs a single transfer with no descriptor fetch when chaining is switched off.

Top module: `tcb_chain_seq`

## Requirements
- R1: A synchronous active-high reset returns the sequencer to idle: `seq_active`, `xfer_req`, `mem_rd_req` and `chain_done` are low, and all parameter-loaded flags and enables are cleared.
- R2: Register selects are 0 = index, 1 = modifier, 2 = count, 3 = link pointer, 4 = control. Control bit 0 enables DMA, bit 1 enables the port and bit 2 enables chaining. Writes to selects 0 to 3 are ignored while `seq_active` is high.
- R3: A link-pointer write made while idle starts a chain when index, modifier and count have each been written since the last start, and DMA, port and chaining are all enabled. The first transfer uses the parameter registers, and no descriptor read happens before that transfer's last word.
- R4: If any one of the four start conditions is missing, a link-pointer write starts nothing. Every start clears the parameter-loaded flags, so a new sequence needs all three parameters written again.
- R5: With chaining disabled, a control write that sets DMA and port enables while all three parameters are loaded runs exactly one transfer from the parameter registers. It performs no descriptor fetch and then returns to idle.
- R6: While a transfer runs with a nonzero count, `xfer_req` is high and `xfer_addr` equals the index. Each cycle in which `mover_done` is high with `xfer_req` moves the index by the modifier (modulo 2^16) and lowers the count by one. A transfer with count zero moves no words.
- R7: After a chained transfer ends with a nonzero link, the block reads the four words at link, link+1, link+2 and link+3. These hold, in that order, the next link, count, modifier and index. `mem_rd_req` and `mem_rd_addr` hold steady until `mem_rd_valid` is seen.
- R8: `xfer_req` never overlaps `mem_rd_req`. The next transfer starts only after all four words have arrived, and it uses all four new values together.
- R9: When a transfer ends and no further descriptor follows (link zero, or single mode), `chain_done` pulses high for one cycle, in the first cycle in which `seq_active` is low.
- R10: A link-pointer write made while a chain is active is ignored; the chain keeps following the descriptors it already holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 3 | Register select |
| reg_wr_data | input | 16 | Register write data |
| mem_rd_req | output | 1 | Descriptor read request, held until valid |
| mem_rd_addr | output | 16 | Descriptor word address |
| mem_rd_valid | input | 1 | Read data valid; accepts the current request |
| mem_rd_data | input | 16 | Read data |
| xfer_req | output | 1 | Word address valid toward the data mover |
| xfer_addr | output | 16 | Current word address |
| mover_done | input | 1 | Data mover finished the presented word |
| seq_active | output | 1 | A transfer or fetch is in progress |
| chain_done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
The bench targets the following corner cases, and each one catches a specific kind of wrong design:
- **Start qualification.** Link writes are made with each start condition missing in turn. A design that ignored one condition would start a chain early.
- **Stale parameters.** A start is attempted with only two parameters freshly written. A design that never cleared the loaded flags would start anyway.
- **Zero-count descriptor and negative modifier.** A chain through a zero-count descriptor catches off-by-one count handling. A negative modifier catches a design that lost the wrap-around.
- **Splicing.** A link write lands in the middle of a running chain. A design that accepted it would fetch from the new address.
- **Stalls.** Every other memory and mover cycle is stalled. A design that did not hold its request would skip or repeat words.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

    localparam int ADDR_W    = 16;
    localparam int CNT_W     = 16;
    localparam int WORD_W    = (ADDR_W > CNT_W) ? ADDR_W : CNT_W;
    localparam int SEL_W     = 3;
    localparam int TCB_WORDS = 4;
    localparam int SLOT_W    = $clog2(TCB_WORDS);

    localparam int CTL_DMA   = 0;
    localparam int CTL_PORT  = 1;
    localparam int CTL_CHAIN = 2;
    localparam int CTL_W     = 3;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [SLOT_W-1:0] slot_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_INDEX = 3'd0,
        SEL_STEP  = 3'd1,
        SEL_COUNT = 3'd2,
        SEL_LINK  = 3'd3,
        SEL_CTRL  = 3'd4
    } sel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FETCH
    } seq_state_e;

    typedef struct packed {
        addr_t link;
        cnt_t  count;
        addr_t step;
        addr_t index;
    } tcb_t;

    function automatic addr_t slot_addr(addr_t base, slot_t slot);
        return base + addr_t'(slot);
    endfunction

    function automatic logic last_slot(slot_t slot);
        return slot == slot_t'(TCB_WORDS - 1);
    endfunction

endpackage

// File: rtl/dmaseq_ctl.sv
module dmaseq_ctl
    import dmaseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [CTL_W-1:0] wr_ctl,
    input  logic             idle,
    output logic             start_chain,
    output logic             start_single,
    output logic             chain_mode
);

    logic       dma_en, port_en, chain_en;
    logic [2:0] loaded;
    logic       wr_ok, all_loaded;

    assign wr_ok      = wr_en && idle;
    assign all_loaded = &loaded;

    assign start_chain  = wr_ok && (wr_sel == SEL_LINK) && all_loaded
                          && dma_en && port_en && chain_en;
    assign start_single = wr_ok && (wr_sel == SEL_CTRL) && all_loaded
                          && wr_ctl[CTL_DMA] && wr_ctl[CTL_PORT] && !wr_ctl[CTL_CHAIN];

    always_ff @(posedge clk) begin
        if (rst) begin
            dma_en     <= 1'b0;
            port_en    <= 1'b0;
            chain_en   <= 1'b0;
            loaded     <= '0;
            chain_mode <= 1'b0;
        end else begin
            if (wr_en && (wr_sel == SEL_CTRL)) begin
                dma_en   <= wr_ctl[CTL_DMA];
                port_en  <= wr_ctl[CTL_PORT];
                chain_en <= wr_ctl[CTL_CHAIN];
            end
            if (start_chain || start_single) begin
                loaded     <= '0;
                chain_mode <= start_chain;
            end else if (wr_ok) begin
                case (wr_sel)
                    SEL_INDEX: loaded[0] <= 1'b1;
                    SEL_STEP:  loaded[1] <= 1'b1;
                    SEL_COUNT: loaded[2] <= 1'b1;
                    default:   ;
                endcase
            end
        end
    end

endmodule

// File: rtl/dmaseq_params.sv
module dmaseq_params
    import dmaseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we_index,
    input  logic  we_step,
    input  logic  we_count,
    input  logic  we_link,
    input  word_t wdata,
    input  logic  load,
    input  tcb_t  tcb,
    input  logic  advance,
    output addr_t index,
    output addr_t step,
    output cnt_t  count,
    output addr_t link
);

    always_ff @(posedge clk) begin
        if (rst) begin
            index <= '0;
            step  <= '0;
            count <= '0;
            link  <= '0;
        end else if (load) begin
            index <= tcb.index;
            step  <= tcb.step;
            count <= tcb.count;
            link  <= tcb.link;
        end else begin
            if (we_index) index <= wdata[ADDR_W-1:0];
            if (we_step)  step  <= wdata[ADDR_W-1:0];
            if (we_count) count <= wdata[CNT_W-1:0];
            if (we_link)  link  <= wdata[ADDR_W-1:0];
            if (advance) begin
                index <= index + step;
                count <= count - cnt_t'(1);
            end
        end
    end

endmodule

// File: rtl/dmaseq_fetch.sv
module dmaseq_fetch
    import dmaseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  addr_t base,
    output logic  rd_req,
    output addr_t rd_addr,
    input  logic  rd_valid,
    input  word_t rd_data,
    output logic  tcb_valid,
    output tcb_t  tcb
);

    logic  busy;
    slot_t slot;
    addr_t base_q;

    assign rd_req  = busy;
    assign rd_addr = slot_addr(base_q, slot);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            slot      <= '0;
            base_q    <= '0;
            tcb       <= '0;
            tcb_valid <= 1'b0;
        end else begin
            tcb_valid <= 1'b0;
            if (start) begin
                busy   <= 1'b1;
                slot   <= '0;
                base_q <= base;
            end else if (busy && rd_valid) begin
                case (slot)
                    2'd0:    tcb.link  <= rd_data[ADDR_W-1:0];
                    2'd1:    tcb.count <= rd_data[CNT_W-1:0];
                    2'd2:    tcb.step  <= rd_data[ADDR_W-1:0];
                    default: tcb.index <= rd_data[ADDR_W-1:0];
                endcase
                slot <= slot + slot_t'(1);
                if (last_slot(slot)) begin
                    busy      <= 1'b0;
                    tcb_valid <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/tcb_chain_seq.sv
module tcb_chain_seq
    import dmaseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [SEL_W-1:0]  reg_wr_sel,
    input  logic [WORD_W-1:0] reg_wr_data,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic              xfer_req,
    output logic [ADDR_W-1:0] xfer_addr,
    input  logic              mover_done,
    output logic              seq_active,
    output logic              chain_done
);

    seq_state_e state_q, state_d;
    logic  idle, wr_here;
    logic  start_chain, start_single, chain_mode;
    logic  we_index, we_step, we_count, we_link;
    addr_t cur_index, cur_step, cur_link;
    cnt_t  cur_count;
    tcb_t  fetched;
    logic  tcb_valid;
    logic  run_end, follow, advance, load_tcb;
    logic  done_q;

    assign idle    = (state_q == ST_IDLE);
    assign wr_here = reg_wr_en && idle;

    assign we_index = wr_here && (reg_wr_sel == SEL_INDEX);
    assign we_step  = wr_here && (reg_wr_sel == SEL_STEP);
    assign we_count = wr_here && (reg_wr_sel == SEL_COUNT);
    assign we_link  = wr_here && (reg_wr_sel == SEL_LINK);

    assign run_end  = (state_q == ST_RUN) && (cur_count == '0);
    assign follow   = run_end && chain_mode && (cur_link != '0);
    assign advance  = (state_q == ST_RUN) && (cur_count != '0) && mover_done;
    assign load_tcb = (state_q == ST_FETCH) && tcb_valid;

    dmaseq_ctl ctl_i (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (reg_wr_en),
        .wr_sel       (reg_wr_sel),
        .wr_ctl       (reg_wr_data[CTL_W-1:0]),
        .idle         (idle),
        .start_chain  (start_chain),
        .start_single (start_single),
        .chain_mode   (chain_mode)
    );

    dmaseq_params params_i (
        .clk      (clk),
        .rst      (rst),
        .we_index (we_index),
        .we_step  (we_step),
        .we_count (we_count),
        .we_link  (we_link),
        .wdata    (reg_wr_data),
        .load     (load_tcb),
        .tcb      (fetched),
        .advance  (advance),
        .index    (cur_index),
        .step     (cur_step),
        .count    (cur_count),
        .link     (cur_link)
    );

    dmaseq_fetch fetch_i (
        .clk       (clk),
        .rst       (rst),
        .start     (follow),
        .base      (cur_link),
        .rd_req    (mem_rd_req),
        .rd_addr   (mem_rd_addr),
        .rd_valid  (mem_rd_valid),
        .rd_data   (mem_rd_data),
        .tcb_valid (tcb_valid),
        .tcb       (fetched)
    );

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (start_chain || start_single) state_d = ST_RUN;
            ST_RUN:   if (run_end) state_d = follow ? ST_FETCH : ST_IDLE;
            ST_FETCH: if (tcb_valid) state_d = ST_RUN;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= run_end && !follow;
        end
    end

    assign xfer_req   = (state_q == ST_RUN) && (cur_count != '0);
    assign xfer_addr  = cur_index;
    assign seq_active = !idle;
    assign chain_done = done_q;

endmodule

// File: rtl/tcb_chain_seq_chk.sv
module tcb_chain_seq_chk
    import dmaseq_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  xfer_req,
    input addr_t xfer_addr,
    input logic  mover_done,
    input logic  mem_rd_req,
    input logic  mem_rd_valid,
    input addr_t mem_rd_addr,
    input logic  seq_active,
    input logic  chain_done,
    input addr_t step
);

    a_r6_req_only_active: assert property (@(posedge clk) disable iff (rst)
        xfer_req |-> seq_active);

    a_r6_addr_steps: assert property (@(posedge clk) disable iff (rst)
        (xfer_req && mover_done) |=>
            (!xfer_req || (xfer_addr == addr_t'($past(xfer_addr) + $past(step)))));

    a_r7_read_held: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

    a_r8_no_overlap: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |-> !xfer_req);

    a_r9_done_when_idle: assert property (@(posedge clk) disable iff (rst)
        chain_done |-> !seq_active);

    a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        chain_done |=> !chain_done);

endmodule

bind tcb_chain_seq tcb_chain_seq_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .xfer_req     (xfer_req),
    .xfer_addr    (xfer_addr),
    .mover_done   (mover_done),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_addr  (mem_rd_addr),
    .seq_active   (seq_active),
    .chain_done   (chain_done),
    .step         (cur_step)
);

// File: tb/tcb_chain_seq_tb_top.sv
`timescale 1ns/1ps
module tcb_chain_seq_tb_top;
    import dmaseq_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_wr_en = 1'b0;
    logic [SEL_W-1:0]  reg_wr_sel = '0;
    logic [WORD_W-1:0] reg_wr_data = '0;
    logic              mem_rd_req;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic              mem_rd_valid;
    logic [WORD_W-1:0] mem_rd_data;
    logic              xfer_req;
    logic [ADDR_W-1:0] xfer_addr;
    logic              mover_done;
    logic              seq_active;
    logic              chain_done;

    tcb_chain_seq dut_i (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .xfer_req(xfer_req), .xfer_addr(xfer_addr), .mover_done(mover_done),
        .seq_active(seq_active), .chain_done(chain_done)
    );

    initial forever #10 clk = ~clk;

    int total = 0, fails = 0;
    bit finished = 0;

    logic [15:0] mem [0:63];
    logic [15:0] addr_log [0:255];
    logic [15:0] fetch_log [0:63];
    int          fetch_at [0:63];
    int n_addr = 0, n_fetch = 0, done_count = 0, active_cycles = 0;
    int stall_mode = 0;
    int cyc = 0;

    logic [15:0] exp_addr [0:255];
    logic [15:0] exp_fetch [0:63];
    int n_exp = 0, n_expf = 0;

    // Memory and data mover responder
    initial begin
        mover_done = 1'b0;
        mem_rd_valid = 1'b0;
        mem_rd_data = '0;
        forever begin
            @(negedge clk);
            cyc++;
            if (chain_done) done_count++;
            if (seq_active) active_cycles++;
            if (xfer_req && (stall_mode == 0 || cyc[0])) begin
                if (n_addr < 256) addr_log[n_addr] = xfer_addr;
                n_addr++;
                mover_done = 1'b1;
            end else begin
                mover_done = 1'b0;
            end
            if (mem_rd_req && (stall_mode == 0 || !cyc[0])) begin
                if (n_fetch < 64) begin
                    fetch_log[n_fetch] = mem_rd_addr;
                    fetch_at[n_fetch] = n_addr;
                end
                n_fetch++;
                mem_rd_valid = 1'b1;
                mem_rd_data = mem[mem_rd_addr[5:0]];
            end else begin
                mem_rd_valid = 1'b0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int sel, input logic [15:0] data);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_wr_sel = SEL_W'(sel);
        reg_wr_data = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic clear_logs();
        n_addr = 0; n_fetch = 0; done_count = 0; active_cycles = 0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        repeat (2) @(negedge clk);
        while (seq_active && guard < 4000) begin
            @(negedge clk);
            guard++;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic model(input logic [15:0] idx, input logic [15:0] stp,
                         input logic [15:0] cnt, input logic [15:0] link,
                         input bit chained);
        logic [15:0] a, s, c, l, d;
        a = idx; s = stp; c = cnt; l = link;
        n_exp = 0; n_expf = 0;
        for (int hop = 0; hop < 8; hop++) begin
            for (int k = 0; k < int'(c); k++) begin
                exp_addr[n_exp] = a;
                n_exp++;
                a = a + s;
            end
            if (!chained || l == 16'd0) break;
            d = l;
            for (int w = 0; w < 4; w++) begin
                exp_fetch[n_expf] = d + 16'(w);
                n_expf++;
            end
            l = mem[d[5:0]];
            c = mem[d[5:0] + 6'd1];
            s = mem[d[5:0] + 6'd2];
            a = mem[d[5:0] + 6'd3];
        end
    endtask

    task automatic compare(input string req);
        int bad = -1;
        if (n_addr == n_exp)
            for (int i = 0; i < n_exp; i++)
                if (bad < 0 && addr_log[i] !== exp_addr[i]) bad = i;
        check(n_addr == n_exp, req, "word count", n_addr, n_exp);
        if (bad >= 0)
            check(1'b0, req, $sformatf("word %0d address", bad), addr_log[bad], exp_addr[bad]);
        else
            check(1'b1, req, "word addresses", 0, 0);
        bad = -1;
        if (n_fetch == n_expf)
            for (int i = 0; i < n_expf; i++)
                if (bad < 0 && fetch_log[i] !== exp_fetch[i]) bad = i;
        check(n_fetch == n_expf && bad < 0, req, "descriptor reads",
              bad >= 0 ? longint'(fetch_log[bad]) : longint'(n_fetch),
              bad >= 0 ? longint'(exp_fetch[bad]) : longint'(n_expf));
        check(done_count == 1, req, "done pulses", done_count, 1);
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [15:0] mods [3];
        mods = '{16'd1, 16'd2, 16'hFFFF};
        for (int i = 0; i < 64; i++) mem[i] = 16'(i * 7 + 3);
        // descriptors: link, count, modifier, index
        mem[8]  = 16'd16; mem[9]  = 16'd3; mem[10] = 16'd2;     mem[11] = 16'h0200;
        mem[16] = 16'd24; mem[17] = 16'd0; mem[18] = 16'd1;     mem[19] = 16'h0300;
        mem[24] = 16'd0;  mem[25] = 16'd2; mem[26] = 16'hFFFF;  mem[27] = 16'h0400;
        mem[40] = 16'd0;  mem[41] = 16'd5; mem[42] = 16'd1;     mem[43] = 16'h0700;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!seq_active && !chain_done, "R1", "active/done after reset",
              {seq_active, chain_done}, 0);
        check(!xfer_req, "R1", "xfer_req after reset", xfer_req, 0);
        check(!mem_rd_req, "R1", "mem_rd_req after reset", mem_rd_req, 0);

        // R5/R6 single transfers over modifiers, counts and stall modes
        for (int sm = 0; sm < 2; sm++)
            for (int mi = 0; mi < 3; mi++)
                for (int c = 0; c < 5; c++) begin
                    stall_mode = sm;
                    wr(0, 16'h0100 + 16'(c));
                    wr(1, mods[mi]);
                    wr(2, 16'(c));
                    clear_logs();
                    wr(4, 16'b011);
                    wait_idle();
                    model(16'h0100 + 16'(c), mods[mi], 16'(c), 16'd0, 1'b0);
                    compare($sformatf("R5 R6 single mod=%0h cnt=%0d", mods[mi], c));
                end

        // R3/R7/R8/R9 chain through three descriptors, incl. a zero-count one
        for (int sm = 0; sm < 2; sm++) begin
            stall_mode = sm;
            wr(0, 16'h0010); wr(1, 16'd1); wr(2, 16'd2);
            wr(4, 16'b111);
            clear_logs();
            wr(3, 16'd8);
            wait_idle();
            model(16'h0010, 16'd1, 16'd2, 16'd8, 1'b1);
            compare("R3 R7 R8 R9 chain");
            check(n_fetch > 0 && fetch_at[0] == 2, "R3", "words before first read",
                  fetch_at[0], 2);
        end

        // R4 start qualification, one missing condition at a time
        stall_mode = 0;
        clear_logs();
        wr(4, 16'b011);                 // not loaded: no single start
        wr(0, 16'h0020); wr(1, 16'd1); wr(2, 16'd3);
        wr(3, 16'd8);                   // chaining disabled
        repeat (10) @(negedge clk);
        check(active_cycles == 0 && n_fetch == 0, "R4", "start with chaining off",
              active_cycles, 0);
        wr(4, 16'b110); wr(3, 16'd8);   // DMA disabled
        repeat (10) @(negedge clk);
        check(active_cycles == 0, "R4", "start with DMA off", active_cycles, 0);
        wr(4, 16'b101); wr(3, 16'd8);   // port disabled
        repeat (10) @(negedge clk);
        check(active_cycles == 0, "R4", "start with port off", active_cycles, 0);
        // R9 chain started with a zero link runs only the first transfer
        wr(4, 16'b111);
        clear_logs();
        wr(3, 16'd0);
        wait_idle();
        model(16'h0020, 16'd1, 16'd3, 16'd0, 1'b1);
        compare("R9 zero link");
        // R4 loaded flags cleared by the start: count not rewritten
        clear_logs();
        wr(0, 16'h0030); wr(1, 16'd4);
        wr(3, 16'd8);
        repeat (10) @(negedge clk);
        check(active_cycles == 0, "R4", "start without fresh count", active_cycles, 0);
        wr(2, 16'd2);
        clear_logs();
        wr(3, 16'd8);
        wait_idle();
        model(16'h0030, 16'd4, 16'd2, 16'd8, 1'b1);
        compare("R4 R3 start after full load");

        // R10/R2 link and index writes during an active chain are ignored
        stall_mode = 1;
        wr(0, 16'h0050); wr(1, 16'd3); wr(2, 16'd4);
        clear_logs();
        wr(3, 16'd8);
        wr(3, 16'd40);
        wr(0, 16'h0999);
        wait_idle();
        model(16'h0050, 16'd3, 16'd4, 16'd8, 1'b1);
        compare("R10 R2 splice ignored");

        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule